// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial-peripheral-interface master that a processor drives through a small word-wide register bus. Software queues transmit words into a 64-entry transmit FIFO and sets a start bit. The engine then shifts each queued word out on the serial data line and captures one returning word per transmitted word into a 64-entry receive FIFO. Software drains that FIFO by reading the receive window.

Each of the four chip-select lines has its own four setup bits: clock phase, clock idle polarity, select hold across words, and active-high select. Which line is used for an exchange comes from the control word, along with the word length (1 to 32 bits) and a two-stage serial clock divider. A single interrupt line combines a transmit-FIFO-empty condition and a receive-data-ready condition, each behind its own enable bit.

Top module: `spim_core`

## Requirements
- R1: After reset all four select lines sit at their inactive level (high, since every setup bit is zero), sclk and mosi are 0, irq is 0, the control word (offset 0x08) reads 0, and the status word (offset 0x18) reads 0x1.
- R2: The control word (0x08), the channel setup word (0x0C) and the interrupt mask word (0x10) read back the last value written; offset 0x04 and unmapped offsets read 0.
- R3: Writing 1 to control bit 2 while control bit 0 is set shifts every queued transmit word. Bit 2 reads 1 until the transmit FIFO is empty and the last word has finished, then it clears itself; writing 0 to it has no effect.
- R4: Control bits 24:20 hold word length minus one. Each word is sent most significant bit first as that many bits, and sclk makes exactly two transitions per bit.
- R5: Every word shifted produces one received word. It is right-justified in the read data of offset 0x00 with the upper bits zero. Each read of 0x00 removes one entry, and status bit 3 reads 1 exactly while the receive FIFO holds a word.
- R6: For the line chosen by control bits 19:18 (value n), setup bit n selects clock phase (0: capture on the leading edge; 1: drive on the leading edge, capture on the trailing edge) and setup bit n+4 sets the level sclk idles at.
- R7: Only the chosen select line is driven active, and only during an exchange. Setup bit n+12 makes line n active high; otherwise it is active low.
- R8: With setup bit n+8 set, line n stays active across consecutive queued words. With it clear, the line goes inactive between words, for one serial half period.
- R9: One sclk half period lasts (P+1)·2^E system clocks, where P is control bits 15:12 and E is control bits 11:8.
- R10: Writes to the transmit window (0x04) are dropped while 64 words are queued. A read of 0x00 with the receive FIFO empty returns 0.
- R11: irq is high when status bit 0 (transmit FIFO empty) and mask bit 0 are both set, or when status bit 3 and mask bit 3 are both set.
- R12: While control bit 0 is clear no word is started, even if bit 2 is set; queued words remain in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_o | output | 4 | Chip-select lines, level set per line |

## Verification
The embedded properties check several rules on every cycle. The start bit must fall once the engine is idle with nothing queued. A disabled engine must stay idle, and a select line may be active only during an exchange. The edge counter must stay inside the programmed word length, and sclk must hold still between divider ticks. The divider ticks must be spaced apart, and a full FIFO must keep its count under another push. Only the bench scenarios can show the rest, because those need a modelled peripheral on the serial lines. These are the captured data values in all four clock modes, the bit counts, hold versus release of the select line, the measured divider period, the 65th-word drop, and the combined interrupt line.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NUM_CS = 4;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned POST_W = 4;

  // register offsets decoded by software
  localparam logic [ADDR_W-1:0] OFS_RXD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h18;

  // control word fields
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_XCH  = 2;
  localparam int unsigned CB_POST = 8;
  localparam int unsigned CB_PRE  = 12;
  localparam int unsigned CB_SEL  = 18;
  localparam int unsigned CB_LEN  = 20;

  // channel setup nibbles
  localparam int unsigned FB_PHA  = 0;
  localparam int unsigned FB_POL  = 4;
  localparam int unsigned FB_HOLD = 8;
  localparam int unsigned FB_CSHI = 12;

  // status / mask bits
  localparam int unsigned SB_TXE = 0;
  localparam int unsigned SB_RXR = 3;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rd_data = empty ? '0 : mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  // R10
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(cnt_q)));

  // R5
  fifo_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && pop && !push) |=> empty);
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int unsigned DIV_W  = 20,
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre,
  input  logic [POST_W-1:0] post,
  output logic              tick
);
  logic [DIV_W-1:0] span, limit;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign span  = (DIV_W'(pre) + DIV_W'(1)) << post;
  assign limit = span - DIV_W'(1);
  assign tick  = run && (cnt_q == limit);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  div_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             hold,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             tick,
  input  logic             tx_empty,
  input  logic [W-1:0]     tx_data,
  input  logic             rx_full,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [W-1:0]     rx_data,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_act,
  output logic             idle
);
  localparam int unsigned CNT_W = LEN_W + 1;

  eng_state_e       st_q, st_d;
  logic [CNT_W-1:0] edge_q, edge_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [W-1:0]     txs_q, txs_d, rxs_q, rxs_d;
  logic             mosi_q, mosi_d, sclk_q, sclk_d, cs_q, cs_d;
  logic [LEN_W-1:0] shamt;
  logic [W-1:0]     aligned, rx_next;
  logic             can_start, last_edge, sample_now, load;

  assign shamt      = LEN_W'(W - 1) - len_m1;
  assign aligned    = tx_data << shamt;
  assign can_start  = go && !tx_empty && !rx_full;
  assign last_edge  = (edge_q == {len_q, 1'b1});
  assign sample_now = (~edge_q[0]) ^ cpha;
  assign rx_next    = sample_now ? {rxs_q[W-2:0], miso} : rxs_q;

  always_comb begin
    st_d    = st_q;
    edge_d  = edge_q;
    len_d   = len_q;
    txs_d   = txs_q;
    rxs_d   = rxs_q;
    mosi_d  = mosi_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    load    = 1'b0;
    rx_push = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        sclk_d = cpol;
        if (can_start) load = 1'b1;
        else           cs_d = 1'b0;
      end
      ENG_SHIFT: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          if (sample_now) rxs_d = rx_next;
          else begin
            mosi_d = txs_q[W-1];
            txs_d  = txs_q << 1;
          end
          if (last_edge) begin
            rx_push = 1'b1;
            st_d    = ENG_GAP;
            if (!hold) cs_d = 1'b0;
          end else begin
            edge_d = edge_q + 1'b1;
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          if (can_start) load = 1'b1;
          else begin
            st_d = ENG_IDLE;
            cs_d = 1'b0;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
    if (load) begin
      st_d   = ENG_SHIFT;
      edge_d = '0;
      len_d  = len_m1;
      txs_d  = cpha ? aligned : (aligned << 1);
      mosi_d = aligned[W-1];
      rxs_d  = '0;
      cs_d   = 1'b1;
      sclk_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      edge_q <= '0;
      len_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      mosi_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      len_q  <= len_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      mosi_q <= mosi_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
    end
  end

  assign tx_pop  = load;
  assign rx_data = rx_next;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign cs_act  = cs_q;
  assign idle    = (st_q == ENG_IDLE);

  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SHIFT) |-> (edge_q <= {len_q, 1'b1}));

  // R8
  cs_during_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SHIFT) |-> cs_q);

  // R6
  sclk_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SHIFT && !tick) |=> $stable(sclk_q));

  // R5
  push_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (st_q == ENG_GAP));
endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned DIV_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_o
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2_q, rst_s1_q} <= 2'b00;
    else        {rst_s2_q, rst_s1_q} <= {rst_s1_q, 1'b1};
  end
  assign rst_ni = rst_s2_q;

  logic [WORD_W-1:0] ctrl_q, ctrl_d, cfg_q, ien_q;
  logic              ctrl_we, cfg_we, ien_we, tx_we, rx_re;
  logic              xch_done;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, eng_idle, eng_cs, tick;
  logic [WORD_W-1:0] tx_head, rx_word, rx_head;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CS-1:0] pha_v, pol_v, hold_v, cshi_v, cs_on;
  logic [WORD_W-1:0] stat_w;

  assign ctrl_we = bus_req && bus_wr && (bus_addr == OFS_CTRL);
  assign cfg_we  = bus_req && bus_wr && (bus_addr == OFS_CFG);
  assign ien_we  = bus_req && bus_wr && (bus_addr == OFS_IEN);
  assign tx_we   = bus_req && bus_wr && (bus_addr == OFS_TXD);
  assign rx_re   = bus_req && !bus_wr && (bus_addr == OFS_RXD);

  assign xch_done = ctrl_q[CB_XCH] && ctrl_q[CB_EN] && eng_idle && tx_empty;

  always_comb begin
    ctrl_d = ctrl_q;
    if (xch_done) ctrl_d[CB_XCH] = 1'b0;
    if (ctrl_we) begin
      ctrl_d         = bus_wdata;
      ctrl_d[CB_XCH] = bus_wdata[CB_XCH] | (ctrl_q[CB_XCH] & ~xch_done);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      ien_q  <= '0;
    end else begin
      if (ctrl_we || xch_done) ctrl_q <= ctrl_d;
      if (cfg_we)              cfg_q  <= bus_wdata;
      if (ien_we)              ien_q  <= bus_wdata;
    end
  end

  assign sel    = ctrl_q[CB_SEL +: SEL_W];
  assign pha_v  = cfg_q[FB_PHA  +: NUM_CS];
  assign pol_v  = cfg_q[FB_POL  +: NUM_CS];
  assign hold_v = cfg_q[FB_HOLD +: NUM_CS];
  assign cshi_v = cfg_q[FB_CSHI +: NUM_CS];

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_ni), .push(tx_we), .push_data(bus_wdata),
    .pop(tx_pop), .rd_data(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_ni), .push(rx_push), .push_data(rx_word),
    .pop(rx_re), .rd_data(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spim_clkdiv #(.DIV_W(DIV_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_div (
    .clk(clk), .rst_n(rst_ni), .run(!eng_idle),
    .pre(ctrl_q[CB_PRE +: PRE_W]), .post(ctrl_q[CB_POST +: POST_W]),
    .tick(tick)
  );

  spim_shifter #(.W(WORD_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_ni),
    .go(ctrl_q[CB_EN] && ctrl_q[CB_XCH]),
    .cpol(pol_v[sel]), .cpha(pha_v[sel]), .hold(hold_v[sel]),
    .len_m1(ctrl_q[CB_LEN +: LEN_W]), .tick(tick),
    .tx_empty(tx_empty), .tx_data(tx_head), .rx_full(rx_full), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
    .sclk(sclk), .mosi(mosi), .cs_act(eng_cs), .idle(eng_idle)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_on[g] = eng_cs && (sel == SEL_W'(g));
    assign cs_o[g]  = cs_on[g] ? cshi_v[g] : ~cshi_v[g];
  end

  always_comb begin
    stat_w         = '0;
    stat_w[SB_TXE] = tx_empty;
    stat_w[SB_RXR] = !rx_empty;
  end

  always_comb begin
    case (bus_addr)
      OFS_RXD:  bus_rdata = rx_head;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_CFG:  bus_rdata = cfg_q;
      OFS_IEN:  bus_rdata = ien_q;
      OFS_STAT: bus_rdata = stat_w;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = (ien_q[SB_TXE] && tx_empty) || (ien_q[SB_RXR] && !rx_empty);

  // R3
  xch_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[CB_XCH] && ctrl_q[CB_EN] && eng_idle && tx_empty &&
     !(ctrl_we && bus_wdata[CB_XCH])) |=> !ctrl_q[CB_XCH]);

  // R7
  cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (|cs_on) |-> !eng_idle);

  // R12
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl_q[CB_EN] && eng_idle) |=> eng_idle);

  // R10
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_full && tx_we && !tx_pop) |=> tx_full);
endmodule

// File: tb/spim_core_test.sv
module spim_core_test;
  localparam int CLK_PERIOD = 10;

  // vector: sel[42:41] cpol[40] cpha[39] len[38:33] inv[32] word[31:0]
  localparam logic [42:0] VECS [8] = '{
    {2'd0, 1'b0, 1'b0, 6'd8,  1'b0, 32'h0000_00A5},
    {2'd1, 1'b0, 1'b1, 6'd16, 1'b1, 32'h0000_1234},
    {2'd2, 1'b1, 1'b0, 6'd13, 1'b0, 32'hFFFF_F0F3},
    {2'd3, 1'b1, 1'b1, 6'd32, 1'b0, 32'hDEAD_BEEF},
    {2'd0, 1'b1, 1'b1, 6'd1,  1'b0, 32'h0000_0001},
    {2'd1, 1'b1, 1'b0, 6'd31, 1'b1, 32'h1357_9BDF},
    {2'd2, 1'b0, 1'b1, 6'd5,  1'b1, 32'h0000_0013},
    {2'd3, 1'b0, 1'b0, 6'd24, 1'b0, 32'h00C0_FFEE}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_o;
  logic        miso_inv;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // monitor state
  int   cyc = 0, toggles = 0, cs_starts = 0, other_bad = 0, last_tog = -1, last_gap = 0;
  logic prev_sclk = 1'b0, prev_act = 1'b0;
  int   mon_sel = 0;
  logic [3:0] shadow_cshi = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = miso_inv ? ~mosi : mosi;

  spim_core uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o)
  );

  always @(negedge clk) begin
    logic act;
    cyc++;
    if (sclk !== prev_sclk) begin
      toggles++;
      if (last_tog >= 0) last_gap = cyc - last_tog;
      last_tog = cyc;
    end
    prev_sclk = sclk;
    act = (cs_o[mon_sel] === shadow_cshi[mon_sel]);
    if (act && !prev_act) cs_starts++;
    prev_act = act;
    for (int i = 0; i < 4; i++)
      if (i != mon_sel && cs_o[i] !== ~shadow_cshi[i]) other_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic clear_mon(input int s);
    @(posedge clk);
    #1;
    mon_sel = s; toggles = 0; cs_starts = 0; other_bad = 0;
    last_tog = -1; last_gap = 0; prev_sclk = sclk;
    prev_act = (cs_o[s] === shadow_cshi[s]);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] r;
    int n;
    n = 0;
    bus_read(5'h08, r);
    while (r[2] && n < 5000) begin
      bus_read(5'h08, r);
      n++;
    end
    chk(req, {31'd0, r[2]}, 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; miso_inv = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cs_o", {28'd0, cs_o}, 32'hF);
    chk("R1 sclk/mosi/irq", {29'd0, sclk, mosi, irq}, 32'd0);
    bus_read(5'h08, r); chk("R1 ctrl", r, 32'd0);
    bus_read(5'h18, r); chk("R1 status", r, 32'h1);

    // R2 readback
    bus_write(5'h0C, 32'h0000_A5F0); bus_read(5'h0C, r); chk("R2 cfg", r, 32'h0000_A5F0);
    bus_write(5'h10, 32'h0000_0009); bus_read(5'h10, r); chk("R2 ien", r, 32'h9);
    bus_write(5'h08, 32'h0071_F0F1); bus_read(5'h08, r); chk("R2 ctrl", r, 32'h0071_F0F1);
    bus_read(5'h04, r); chk("R2 txd reads 0", r, 32'd0);
    bus_write(5'h08, 32'h0); bus_write(5'h10, 32'h0); bus_write(5'h0C, 32'h0);

    // vector table: R4 R5 R6 R7 R3
    foreach (VECS[k]) begin
      logic [1:0] s; logic pol, pha, inv; int len; logic [31:0] w, exp, cfg;
      s = VECS[k][42:41]; pol = VECS[k][40]; pha = VECS[k][39];
      len = int'(VECS[k][38:33]); inv = VECS[k][32]; w = VECS[k][31:0];
      exp = inv ? ~w : w;
      if (len < 32) exp = exp & ((32'd1 << len) - 32'd1);
      cfg = 32'd0;
      cfg[s] = pha; cfg[4+s] = pol; cfg[8+s] = 1'b1;
      if (s == 2'd3) cfg[15] = 1'b1;
      shadow_cshi = cfg[15:12];
      miso_inv = inv;
      bus_write(5'h0C, cfg);
      bus_write(5'h08, 32'h1 | (32'(s) << 18) | (32'(len - 1) << 20));
      bus_write(5'h04, w);
      clear_mon(int'(s));
      bus_write(5'h08, 32'h5 | (32'(s) << 18) | (32'(len - 1) << 20));
      wait_idle("R3 xch self-clear");
      chk("R6 sclk idle level", {31'd0, sclk}, {31'd0, pol});
      chk("R4 sclk transitions", 32'(toggles), 32'(2 * len));
      chk("R7 select asserted once", 32'(cs_starts), 32'd1);
      chk("R7 other lines idle", 32'(other_bad), 32'd0);
      bus_read(5'h00, r); chk("R5 rx word", r, exp);
      bus_read(5'h18, r); chk("R5 status after read", r, 32'h1);
    end
    miso_inv = 0;

    // R7 active-high idle level of line 1
    shadow_cshi = 4'b0010;
    bus_write(5'h0C, 32'h0000_2000);
    chk("R7 active-high idle", {28'd0, cs_o}, 32'hD);
    shadow_cshi = 4'b0000;
    bus_write(5'h0C, 32'h0);

    // R12 + R10: disabled engine, 65 writes
    bus_write(5'h08, 32'(7) << 20);
    for (int i = 0; i < 65; i++) bus_write(5'h04, 32'(i));
    clear_mon(0);
    bus_write(5'h08, (32'(7) << 20) | 32'h4);
    repeat (40) @(negedge clk);
    chk("R12 no shifting while disabled", 32'(toggles), 32'd0);
    bus_read(5'h18, r); chk("R12 queue kept, no rx", r, 32'd0);
    bus_write(5'h08, (32'(7) << 20) | 32'h5);
    wait_idle("R3 drain 64");
    chk("R8 release between words", 32'(cs_starts), 32'd64);
    chk("R10 only 64 words shifted", 32'(toggles), 32'd1024);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        bus_read(5'h00, r);
        if (r !== 32'(i)) bad++;
      end
      chk("R5 64 words in order", 32'(bad), 32'd0);
    end
    bus_read(5'h00, r); chk("R10 empty read", r, 32'd0);
    bus_read(5'h18, r); chk("R5 rx drained", r, 32'h1);

    // R8 hold across two words
    bus_write(5'h0C, 32'h0000_0100);
    bus_write(5'h08, (32'(7) << 20) | 32'h1);
    bus_write(5'h04, 32'h3C); bus_write(5'h04, 32'hC3);
    clear_mon(0);
    bus_write(5'h08, (32'(7) << 20) | 32'h5);
    wait_idle("R3 hold pair");
    chk("R8 held across words", 32'(cs_starts), 32'd1);
    bus_read(5'h00, r); chk("R5 hold word0", r, 32'h3C);
    bus_read(5'h00, r); chk("R5 hold word1", r, 32'hC3);

    // R9 divider: P=2, E=1 -> 6 clocks
    bus_write(5'h0C, 32'h0);
    bus_write(5'h08, (32'(3) << 20) | (32'd2 << 12) | (32'd1 << 8) | 32'h1);
    bus_write(5'h04, 32'h9);
    clear_mon(0);
    bus_write(5'h08, (32'(3) << 20) | (32'd2 << 12) | (32'd1 << 8) | 32'h5);
    wait_idle("R3 divided");
    chk("R9 half period", 32'(last_gap), 32'd6);
    chk("R9 transitions", 32'(toggles), 32'd8);
    bus_read(5'h00, r); chk("R9 data", r, 32'h9);

    // R11 interrupt
    bus_write(5'h08, (32'(7) << 20) | 32'h1);
    bus_write(5'h10, 32'h1);
    chk("R11 tx empty irq", {31'd0, irq}, 32'd1);
    bus_write(5'h10, 32'h8);
    chk("R11 rx empty no irq", {31'd0, irq}, 32'd0);
    bus_write(5'h04, 32'h5A);
    bus_write(5'h08, (32'(7) << 20) | 32'h5);
    wait_idle("R3 irq word");
    chk("R11 rx ready irq", {31'd0, irq}, 32'd1);
    bus_write(5'h10, 32'h0);
    chk("R11 masked", {31'd0, irq}, 32'd0);
    bus_write(5'h10, 32'h8);
    bus_read(5'h00, r); chk("R11 rx data", r, 32'h5A);
    @(negedge clk);
    chk("R11 irq drops after read", {31'd0, irq}, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule